// File: doc/BRIEF.md
# Condition Code Pass Evaluator

This block decides whether a conditional instruction should execute. It takes an instruction word, the four arithmetic status flags and an execution-mode code, and it drives one pass bit. In the 32-bit instruction mode, the condition field is the top nibble of the instruction word. In the compact 16-bit mode, every instruction is treated as unconditional. When the mode is not valid, nothing passes.

Inside the nibble, the three upper bits choose one of eight flag tests. The lowest bit inverts the result of that test. No value is special-cased, so the "always" selector with the inversion bit set never passes. By default the pass bit is combinational. The `OUT_REG` parameter adds one output register with a synchronous, active-high reset.

Top module: `cond_pass_eval`

## Requirements
- R1: `mode_i` encoding: 2'b01 is the 32-bit mode, 2'b10 is the 16-bit mode, and 2'b00 and 2'b11 are invalid. In the 32-bit mode the condition nibble is `instr_i[INSTR_W-1:INSTR_W-4]`.
- R2: In the 16-bit mode, `pass_o` is 1 for every instruction word and every flag value.
- R3: In either invalid mode, `pass_o` is 0 for every instruction word and every flag value.
- R4: `flags_i` bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. Condition bits 3:1 select the test. 0 means Z set, 1 means C set, 2 means N set, 3 means V set, 4 means C set with Z clear, 5 means N equal to V, 6 means N equal to V with Z clear, and 7 means always true.
- R5: When condition bit 0 is 1, the selected test result is inverted.
- R6: In the 32-bit mode, condition 4'hE passes for every flag value and condition 4'hF passes for none.
- R7: The instruction bits below the condition nibble have no effect on `pass_o`.
- R8: With `OUT_REG`=0, `pass_o` follows its inputs in the same cycle and `rst` has no effect. With `OUT_REG`=1, `pass_o` shows the result for the inputs sampled at the previous rising edge of `clk`, and it is 0 after a cycle with `rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only when OUT_REG=1 |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mode_i | input | 2 | Execution-mode code |
| instr_i | input | INSTR_W | Instruction word |
| flags_i | input | 4 | Status flags {N, Z, C, V} |
| pass_o | output | 1 | Instruction should execute |

## Verification
In the combinational build, the pass bit is due in the same cycle that the inputs change. The bench drives the inputs on the falling edge and samples the output a short delay later, before the next rising edge. In the registered build, the result appears at the first rising edge after the drive. The bench therefore checks it at the following falling edge against the value expected for the held inputs. Both builds are swept over every mode, condition and flag combination, and the low instruction bits are varied from vector to vector.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int COND_W = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_A32  = 2'b01,
    MODE_T16  = 2'b10,
    MODE_OFF2 = 2'b11
  } exec_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;
endpackage

// File: rtl/cpe_cond_src.sv
module cpe_cond_src
  import cpe_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [COND_W-1:0] field_i,
  output logic [COND_W-1:0] cond_o,
  output logic              valid_o
);
  always_comb begin
    cond_o  = COND_ALWAYS;
    valid_o = 1'b0;
    case (mode_i)
      MODE_A32: begin
        cond_o  = field_i;
        valid_o = 1'b1;
      end
      MODE_T16: begin
        cond_o  = COND_ALWAYS;
        valid_o = 1'b1;
      end
      default: begin
        cond_o  = COND_ALWAYS;
        valid_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cpe_flag_test.sv
module cpe_flag_test
  import cpe_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  flags_t           flags_i,
  output logic             raw_o
);
  always_comb begin
    case (sel_i)
      3'd0:    raw_o = flags_i.z;
      3'd1:    raw_o = flags_i.c;
      3'd2:    raw_o = flags_i.n;
      3'd3:    raw_o = flags_i.v;
      3'd4:    raw_o = flags_i.c & ~flags_i.z;
      3'd5:    raw_o = (flags_i.n == flags_i.v);
      3'd6:    raw_o = (flags_i.n == flags_i.v) & ~flags_i.z;
      default: raw_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cpe_out_stage.sv
module cpe_out_stage #(
  parameter bit OUT_REG = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic raw_i,
  input  logic inv_i,
  output logic pass_o
);
  logic pass_d;
  assign pass_d = valid_i & (raw_i ^ inv_i);

  generate
    if (OUT_REG) begin : g_reg
      logic pass_q;
      always_ff @(posedge clk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= pass_d;
      end
      assign pass_o = pass_q;

      // R5: inversion applied to the flag test result, one cycle later
      a_r5_invert: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (pass_o == ($past(raw_i) ^ $past(inv_i))));
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign pass_o = pass_d;

      // R5: inversion applied to the flag test result
      a_r5_invert: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> (pass_o == (raw_i ^ inv_i)));
    end
  endgenerate
endmodule

// File: rtl/cond_pass_eval.sv
module cond_pass_eval
  import cpe_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [3:0]         flags_i,
  output logic               pass_o
);
  localparam int TOP_LSB = INSTR_W - COND_W;

  initial begin
    if (INSTR_W < COND_W + 1) $error("INSTR_W too small");
  end

  logic [COND_W-1:0] field;
  logic [COND_W-1:0] cond;
  logic              valid;
  logic              raw;
  logic              unused_low_bits;

  assign field           = instr_i[INSTR_W-1:TOP_LSB];
  assign unused_low_bits = ^instr_i[TOP_LSB-1:0];

  cpe_cond_src u_src (
    .mode_i  (mode_i),
    .field_i (field),
    .cond_o  (cond),
    .valid_o (valid)
  );

  cpe_flag_test u_test (
    .sel_i   (cond[COND_W-1:1]),
    .flags_i (flags_t'(flags_i)),
    .raw_o   (raw)
  );

  cpe_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid),
    .raw_i   (raw),
    .inv_i   (cond[0]),
    .pass_o  (pass_o)
  );

  generate
    if (OUT_REG) begin : g_chk_reg
      a_r2_thumb_pass: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_T16) |=> pass_o);
      a_r3_invalid_block: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_OFF || mode_i == MODE_OFF2) |=> !pass_o);
      a_r6_always: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_A32 && field == 4'hE) |=> pass_o);
      a_r6_never: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_A32 && field == 4'hF) |=> !pass_o);
    end else begin : g_chk_comb
      a_r2_thumb_pass: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_T16) |-> pass_o);
      a_r3_invalid_block: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_OFF || mode_i == MODE_OFF2) |-> !pass_o);
      a_r6_always: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_A32 && field == 4'hE) |-> pass_o);
      a_r6_never: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_A32 && field == 4'hF) |-> !pass_o);
    end
  endgenerate
endmodule

// File: tb/cond_pass_eval_tb_top.sv
`timescale 1ns/1ps
module cond_pass_eval_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] instr = '0;
  logic [3:0]   flags = 4'h0;
  logic         pass_c;
  logic         pass_r;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cond_pass_eval #(.INSTR_W(W), .OUT_REG(1'b0)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .instr_i(instr),
    .flags_i(flags), .pass_o(pass_c)
  );

  cond_pass_eval #(.INSTR_W(W), .OUT_REG(1'b1)) dut_reg_i (
    .clk(clk), .rst(rst), .mode_i(mode), .instr_i(instr),
    .flags_i(flags), .pass_o(pass_r)
  );

  function automatic logic model(input int m, input int cnd, input int fl);
    logic n, z, c, v, r;
    int   k;
    n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
    if (m == 1)      k = cnd;
    else if (m == 2) k = 14;
    else             return 1'b0;
    case (k >> 1)
      0: r = z;
      1: r = c;
      2: r = n;
      3: r = v;
      4: r = c && !z;
      5: r = (n == v);
      6: r = (n == v) && !z;
      default: r = 1'b1;
    endcase
    if (k % 2 == 1) r = !r;
    return r;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: mode=%0d instr=%h flags=%h actual=%b expected=%b",
               req, mode, instr, flags, act, exp);
    end
  endtask

  function automatic string req_of(input int m, input int cnd);
    if (m == 2) return "R2";
    if (m == 0 || m == 3) return "R3";
    if (cnd >= 14) return "R6";
    if (cnd % 2 == 1) return "R5";
    return "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset clears the registered output and leaves the combinational one alone
    @(negedge clk);
    mode = 2'b10; instr = 32'h0000_0000; flags = 4'h0;
    @(negedge clk);
    chk("R8", pass_r, 1'b0);
    chk("R8", pass_c, 1'b1);
    @(negedge clk);
    chk("R8", pass_r, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", pass_r, 1'b1);

    // R1 R2 R3 R4 R5 R6 R7: full sweep with varied low instruction bits
    for (int m = 0; m < 4; m++) begin
      for (int cnd = 0; cnd < 16; cnd++) begin
        for (int fl = 0; fl < 16; fl++) begin
          logic e;
          logic [27:0] low;
          low = 28'((m * 256 + cnd * 16 + fl) * 32'h9E3779B) ^ 28'h5A5A5A5;
          @(negedge clk);
          mode  = 2'(m);
          instr = {4'(cnd), low};
          flags = 4'(fl);
          e = model(m, cnd, fl);
          #2;
          chk(req_of(m, cnd), pass_c, e);
          @(negedge clk);
          chk("R8", pass_r, e);
        end
      end
    end

    // R7: low bits all ones against all zeros
    for (int cnd = 0; cnd < 16; cnd++) begin
      logic e;
      e = model(1, cnd, 4'b0110);
      @(negedge clk);
      mode = 2'b01; flags = 4'b0110; instr = {4'(cnd), 28'hFFF_FFFF};
      #2 chk("R7", pass_c, e);
      @(negedge clk);
      instr = {4'(cnd), 28'h000_0000};
      #2 chk("R7", pass_c, e);
    end

    // R8: a registered result that is changing shows the held value until the edge
    @(negedge clk);
    mode = 2'b01; instr = {4'hF, 28'h0}; flags = 4'h0;
    @(negedge clk);
    chk("R8", pass_r, 1'b0);
    mode = 2'b10;
    #2 chk("R8", pass_r, 1'b0);
    chk("R2", pass_c, 1'b1);
    @(negedge clk);
    chk("R8", pass_r, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule